// File: doc/BRIEF.md
# Serial Address and Mode Decoder

This block turns two bit-serial address streams into parallel transfer commands for a memory array built from many identical planes. A row word and a column word, each eight bits, arrive one bit per address-clock pulse on two separate lines, least significant bit first. The upper two bits of the column word are not part of the address. They carry a two-bit operation code that selects a read into output latch A, a read into output latch B, a write from the input latch, or a refresh.

A falling edge of the memory enable captures both words into a staging register. The captured command does not run at once. It runs during the following enable cycle. Reads and refreshes fire on the next falling edge, and a write fires on the rising edge that ends that next cycle. For a refresh, the external row and column are discarded. The row comes from an internal counter that steps once per refresh, and the column is forced to zero. After reset, the first eight enable cycles only prime the device. No command fires until they have been counted.

All inputs are synchronous to a single system clock. The address-clock rising edge is presented as a one-cycle shift strobe. The memory enable is sampled as a level, and its edges are detected inside the block.

Top module: `sadec_top`

## Requirements
- R1: Each shift strobe moves the serial bit into the top of the word and shifts the rest down, so the first of eight bits lands in bit 0 of the row word and of the column word.
- R2: A word captured at enable falling edge N drives `arr_row`/`arr_col` one clock after enable falling edge N+1, not earlier.
- R3: Column word bits [5:0] form `arr_col`. Bit 7 is mode bit M1 and bit 6 is mode bit M0.
- R4: Mode {M1,M0} = 00 pulses `rd_a_stb`, 01 pulses `rd_b_stb`, 10 pulses `wr_c_stb`, and 11 pulses `rfsh_stb`. At most one strobe is high in any clock, and each pulse lasts one clock.
- R5: `rd_a_stb`, `rd_b_stb` and `rfsh_stb` rise one clock after the enable falling edge that executes the command. `wr_c_stb` rises one clock after the enable rising edge that closes that same enable cycle, and not at the falling edge.
- R6: For a refresh, `arr_row` shows the internal refresh counter and `arr_col` shows zero, whatever row and column were shifted in.
- R7: The refresh counter resets to 0 and advances by one on each executed refresh, wrapping from 255 to 0. `refresh_row` always shows the row that the next refresh will use.
- R8: `ready` stays low and no strobe fires until eight enable falling edges have been seen. The ninth falling edge executes the word captured at the eighth, and `ready` never drops again before reset.
- R9: A shift strobe in the same clock as an enable falling edge belongs to the next word. The capture takes the word as it stood before that shift.
- R10: Synchronous active-high reset clears all strobes, `ready`, `arr_row`, `arr_col` and `refresh_row` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adr_shift | input | 1 | One-cycle strobe marking an address-clock rising edge |
| row_sin | input | 1 | Serial row address bit |
| col_sin | input | 1 | Serial column/mode bit |
| ram_en | input | 1 | Memory enable level; high when idle, falling edge captures |
| ready | output | 1 | High once the priming enable cycles are complete |
| arr_row | output | 8 | Row of the command now executing |
| arr_col | output | 6 | Column of the command now executing |
| rd_a_stb | output | 1 | Pulse: array read into latch A |
| rd_b_stb | output | 1 | Pulse: array read into latch B |
| wr_c_stb | output | 1 | Pulse: write from the input latch into the array |
| rfsh_stb | output | 1 | Pulse: refresh of row `arr_row` |
| refresh_row | output | 8 | Row the next refresh will use |

## Verification
Two events can land in the same clock: the enable falling edge that captures a word and the first shift strobe of the following word. The bench provokes this by asserting `adr_shift` in the very clock where `ram_en` drops, then shifting only the remaining seven bits of the next word. It judges the result by the two commands that then execute in turn. Each must show its own row and column unchanged, which fails if the capture took a shifted word or if the next word lost its first bit. The pipeline offset, the write-on-rise timing and the refresh counter wrap are each judged at the ports against a model kept in the bench.

// File: rtl/sadec_pkg.sv
package sadec_pkg;

    localparam int ROW_W          = 8;
    localparam int COL_W          = 6;
    localparam int MODE_W         = 2;
    localparam int CWORD_W        = COL_W + MODE_W;
    localparam int INIT_EN_CYCLES = 8;

    // Operation code, value = {M1, M0} taken from the top of the column word
    typedef enum logic [MODE_W-1:0] {
        OP_RD_A = 2'b00,
        OP_RD_B = 2'b01,
        OP_WR_C = 2'b10,
        OP_RFSH = 2'b11
    } op_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        op_e              op;
    } xfer_t;

    typedef struct packed {
        logic rd_a;
        logic rd_b;
        logic wr_c;
        logic rfsh;
    } stb_t;

    localparam xfer_t XFER_IDLE = '{row: '0, col: '0, op: OP_RD_A};

    // Split the two serial words into a command record
    function automatic xfer_t unpack_words(input logic [ROW_W-1:0]   r,
                                           input logic [CWORD_W-1:0] c);
        xfer_t x;
        x.row = r;
        x.col = c[COL_W-1:0];
        x.op  = op_e'(c[CWORD_W-1 -: MODE_W]);
        return x;
    endfunction

    // Refresh commands take the internal row and a zero column
    function automatic xfer_t resolve(input xfer_t            s,
                                      input logic [ROW_W-1:0] rrow);
        xfer_t x;
        x = s;
        if (s.op == OP_RFSH) begin
            x.row = rrow;
            x.col = '0;
        end
        return x;
    endfunction

endpackage

// File: rtl/sadec_shifter.sv
module sadec_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (shift) begin
            word <= {sin, word[W-1:1]};
        end
    end

    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
        shift |=> (word[W-2:0] == $past(word[W-1:1]))); // R1

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(word)); // R1

endmodule

// File: rtl/sadec_init_gate.sv
module sadec_init_gate #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic ready
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ready = (cnt_q == LAST);

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready); // R8

    AST_READY_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (!ready && !tick) |=> !ready); // R8

endmodule

// File: rtl/sadec_rfsh_ctr.sv
module sadec_rfsh_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] row
);

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
        end else if (adv) begin
            row <= row + 1'b1;
        end
    end

    AST_RFSH_STEP: assert property (@(posedge clk) disable iff (rst)
        adv |=> (row == W'($past(row) + 1'b1))); // R7

    AST_RFSH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(row)); // R7

endmodule

// File: rtl/sadec_top.sv
module sadec_top
    import sadec_pkg::*;
#(
    parameter int INIT_CYCLES = INIT_EN_CYCLES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adr_shift,
    input  logic             row_sin,
    input  logic             col_sin,
    input  logic             ram_en,
    output logic             ready,
    output logic [ROW_W-1:0] arr_row,
    output logic [COL_W-1:0] arr_col,
    output logic             rd_a_stb,
    output logic             rd_b_stb,
    output logic             wr_c_stb,
    output logic             rfsh_stb,
    output logic [ROW_W-1:0] refresh_row
);

    logic [ROW_W-1:0]   row_word;
    logic [CWORD_W-1:0] col_word;

    logic  en_q;
    logic  en_fall;
    logic  en_rise;
    logic  rfsh_adv;
    xfer_t staged_q;
    xfer_t exec_q;
    logic  exec_vld_q;
    stb_t  stb_q;

    // Serial word assembly
    sadec_shifter #(.W(ROW_W)) u_row_sh (
        .clk   (clk),
        .rst   (rst),
        .shift (adr_shift),
        .sin   (row_sin),
        .word  (row_word)
    );

    sadec_shifter #(.W(CWORD_W)) u_col_sh (
        .clk   (clk),
        .rst   (rst),
        .shift (adr_shift),
        .sin   (col_sin),
        .word  (col_word)
    );

    // Enable edge detection (idle level is high)
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b1;
        end else begin
            en_q <= ram_en;
        end
    end

    assign en_fall = en_q & ~ram_en;
    assign en_rise = ~en_q & ram_en;

    sadec_init_gate #(.CYCLES(INIT_CYCLES)) u_init (
        .clk   (clk),
        .rst   (rst),
        .tick  (en_fall),
        .ready (ready)
    );

    assign rfsh_adv = en_fall & ready & (staged_q.op == OP_RFSH);

    sadec_rfsh_ctr #(.W(ROW_W)) u_rfsh (
        .clk (clk),
        .rst (rst),
        .adv (rfsh_adv),
        .row (refresh_row)
    );

    // Two-stage command pipeline: capture at one fall, execute at the next
    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q   <= XFER_IDLE;
            exec_q     <= XFER_IDLE;
            exec_vld_q <= 1'b0;
            stb_q      <= '0;
        end else begin
            stb_q <= '0;
            if (en_fall) begin
                staged_q <= unpack_words(row_word, col_word);
                if (ready) begin
                    exec_q     <= resolve(staged_q, refresh_row);
                    exec_vld_q <= 1'b1;
                    stb_q.rd_a <= (staged_q.op == OP_RD_A);
                    stb_q.rd_b <= (staged_q.op == OP_RD_B);
                    stb_q.rfsh <= (staged_q.op == OP_RFSH);
                end else begin
                    exec_vld_q <= 1'b0;
                end
            end
            if (en_rise && exec_vld_q && exec_q.op == OP_WR_C) begin
                stb_q.wr_c <= 1'b1;
            end
        end
    end

    assign arr_row  = exec_q.row;
    assign arr_col  = exec_q.col;
    assign rd_a_stb = stb_q.rd_a;
    assign rd_b_stb = stb_q.rd_b;
    assign wr_c_stb = stb_q.wr_c;
    assign rfsh_stb = stb_q.rfsh;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_a_stb, rd_b_stb, wr_c_stb, rfsh_stb})); // R4

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (rd_a_stb || rd_b_stb || rfsh_stb) |=> !(rd_a_stb || rd_b_stb || rfsh_stb)); // R4

    AST_FALL_OPS: assert property (@(posedge clk) disable iff (rst)
        (rd_a_stb || rd_b_stb || rfsh_stb) |-> ($past(en_q) && !$past(ram_en))); // R5

    AST_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        wr_c_stb |-> (!$past(en_q) && $past(ram_en))); // R5

    AST_RFSH_COL_ZERO: assert property (@(posedge clk) disable iff (rst)
        rfsh_stb |-> (arr_col == '0)); // R6

    AST_RFSH_ROW_USED: assert property (@(posedge clk) disable iff (rst)
        rfsh_stb |-> (arr_row == ROW_W'(refresh_row - 1'b1))); // R7

    AST_NO_OP_UNREADY: assert property (@(posedge clk) disable iff (rst)
        (rd_a_stb || rd_b_stb || wr_c_stb || rfsh_stb) |-> ready); // R8

endmodule

// File: tb/sim_sadec_top.sv
module sim_sadec_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adr_shift = 1'b0;
    logic       row_sin = 1'b0;
    logic       col_sin = 1'b0;
    logic       ram_en = 1'b1;
    logic       ready;
    logic [7:0] arr_row;
    logic [5:0] arr_col;
    logic       rd_a_stb, rd_b_stb, wr_c_stb, rfsh_stb;
    logic [7:0] refresh_row;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [7:0] prev_row = '0;
    logic [7:0] prev_col = '0;
    int         falls = 0;
    logic [7:0] rcnt = '0;
    logic [7:0] last_row;
    logic [5:0] last_col;

    always #(CLK_PERIOD/2) clk = ~clk;

    sadec_top u0 (
        .clk         (clk),
        .rst         (rst),
        .adr_shift   (adr_shift),
        .row_sin     (row_sin),
        .col_sin     (col_sin),
        .ram_en      (ram_en),
        .ready       (ready),
        .arr_row     (arr_row),
        .arr_col     (arr_col),
        .rd_a_stb    (rd_a_stb),
        .rd_b_stb    (rd_b_stb),
        .wr_c_stb    (wr_c_stb),
        .rfsh_stb    (rfsh_stb),
        .refresh_row (refresh_row)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One enable cycle: shift a word, drop enable, check, raise enable, check
    task automatic cycle_x(input logic [7:0] row, input logic [7:0] colw,
                           input bit first_done, input bit lead_en,
                           input bit lead_r, input bit lead_c);
        bit         fire;
        logic [1:0] mode;
        logic [3:0] exp_f;
        for (int i = (first_done ? 1 : 0); i < 8; i++) begin
            @(negedge clk);
            adr_shift = 1'b1;
            row_sin   = row[i];
            col_sin   = colw[i];
        end
        @(negedge clk);
        adr_shift = lead_en;
        row_sin   = lead_r;
        col_sin   = lead_c;
        ram_en    = 1'b0;
        @(negedge clk);
        adr_shift = 1'b0;
        fire  = (falls >= 8);
        mode  = prev_col[7:6];
        exp_f = {fire && mode == 2'b00, fire && mode == 2'b01, 1'b0, fire && mode == 2'b11};
        chk({rd_a_stb, rd_b_stb, wr_c_stb, rfsh_stb} == exp_f, "R4", "strobes at fall",
            {rd_a_stb, rd_b_stb, wr_c_stb, rfsh_stb}, exp_f);
        chk(wr_c_stb == 1'b0, "R5", "write strobe at fall", wr_c_stb, 0);
        if (fire) begin
            if (mode == 2'b11) begin
                chk(arr_row == rcnt, "R6", "refresh row", arr_row, rcnt);
                chk(arr_col == 6'd0, "R6", "refresh col", arr_col, 0);
                rcnt = rcnt + 8'd1;
            end else begin
                chk(arr_row == prev_row, "R2", "row of executed word", arr_row, prev_row);
                chk(arr_col == prev_col[5:0], "R3", "col of executed word", arr_col, prev_col[5:0]);
            end
        end
        chk(refresh_row == rcnt, "R7", "refresh counter", refresh_row, rcnt);
        falls++;
        chk(ready == (falls >= 8), "R8", "ready", ready, (falls >= 8));
        last_row = arr_row;
        last_col = arr_col;
        ram_en = 1'b1;
        @(negedge clk);
        chk(wr_c_stb == (fire && mode == 2'b10), "R5", "write strobe at rise",
            wr_c_stb, (fire && mode == 2'b10));
        chk({rd_a_stb, rd_b_stb, rfsh_stb} == 3'b000, "R5", "fall strobes after rise",
            {rd_a_stb, rd_b_stb, rfsh_stb}, 0);
        prev_row = row;
        prev_col = colw;
    endtask

    task automatic cycle_n(input logic [7:0] row, input logic [7:0] colw);
        cycle_x(row, colw, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({rd_a_stb, rd_b_stb, wr_c_stb, rfsh_stb} == 4'b0, "R10", "strobes after reset",
            {rd_a_stb, rd_b_stb, wr_c_stb, rfsh_stb}, 0);
        chk(ready == 1'b0, "R10", "ready after reset", ready, 0);
        chk(arr_row == 8'd0 && arr_col == 6'd0, "R10", "address after reset",
            {arr_row, arr_col}, 0);
        chk(refresh_row == 8'd0, "R10", "refresh row after reset", refresh_row, 0);
    endtask

    // Priming: refresh words during the first eight cycles must not fire
    task automatic t_init;
        for (int k = 0; k < 8; k++) begin
            cycle_n(8'h10 + 8'(k), {2'b11, 6'h3F});
        end
        chk(ready == 1'b1, "R8", "ready after eighth fall", ready, 1);
    endtask

    task automatic t_modes;
        cycle_n(8'hA5, {2'b00, 6'h15});
        cycle_n(8'h5A, {2'b01, 6'h2A});
        cycle_n(8'h3C, {2'b10, 6'h01});
        cycle_n(8'hFF, {2'b11, 6'h3F});
        cycle_n(8'h96, {2'b10, 6'h3E});
        cycle_n(8'h00, {2'b00, 6'h00});
        cycle_n(8'h69, {2'b01, 6'h33});
    endtask

    task automatic t_bitorder;
        cycle_n(8'h01, {2'b00, 6'h01});
        cycle_n(8'h80, {2'b01, 6'h20});
        chk(last_row == 8'h01, "R1", "first bit in row bit 0", last_row, 8'h01);
        chk(last_col == 6'h01, "R1", "first bit in col bit 0", last_col, 6'h01);
        cycle_n(8'h00, {2'b00, 6'h00});
        chk(last_row == 8'h80, "R1", "last bit in row bit 7", last_row, 8'h80);
        chk(last_col == 6'h20, "R1", "col bit 5", last_col, 6'h20);
    endtask

    task automatic t_refresh_ignore;
        cycle_n(8'hC3, {2'b11, 6'h2D});
        cycle_n(8'h3C, {2'b11, 6'h12});
        cycle_n(8'h00, {2'b10, 6'h07});
        chk(last_row != 8'h3C, "R6", "external row ignored", last_row, rcnt - 8'd1);
        cycle_n(8'h00, {2'b00, 6'h00});
    endtask

    task automatic t_overlap;
        logic [7:0] xr, xc, yr, yc;
        xr = 8'hB7; xc = {2'b01, 6'h2B};
        yr = 8'h4D; yc = {2'b00, 6'h19};
        cycle_x(xr, xc, 1'b0, 1'b1, yr[0], yc[0]);
        cycle_x(yr, yc, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(last_row == xr, "R9", "captured row before overlapping shift", last_row, xr);
        chk(last_col == xc[5:0], "R9", "captured col before overlapping shift", last_col, xc[5:0]);
        cycle_n(8'h00, {2'b00, 6'h00});
        chk(last_row == yr, "R9", "next row keeps its first bit", last_row, yr);
        chk(last_col == yc[5:0], "R9", "next col keeps its first bit", last_col, yc[5:0]);
    endtask

    task automatic t_wrap;
        for (int k = 0; k < 258; k++) begin
            cycle_n(8'h5A, {2'b11, 6'h00});
        end
        cycle_n(8'h00, {2'b00, 6'h00});
        chk(refresh_row == rcnt, "R7", "counter after wrap", refresh_row, rcnt);
    endtask

    initial begin
        t_reset();
        t_init();
        t_modes();
        t_bitorder();
        t_refresh_ignore();
        t_overlap();
        t_wrap();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule